// File: doc/BRIEF.md
# Segment Access Protection Check

This block judges one memory access or segment-register load against a descriptor that is already cached. It takes the descriptor's access-rights byte, 20-bit limit, granularity flag and 32-bit base. It also takes the current privilege level, the privilege level requested by the selector, the kind of operation, the access size and the offset. It returns a verdict and the linear address (base plus offset). The verdict is one of four values: pass, general-protection fault, stack fault or not-present fault.

All decisions are made combinationally. The verdict, a valid flag and the linear address are captured in one register stage, so each request is answered on the clock edge that follows it. Upstream logic presents one request per cycle. It uses the verdict to allow the access or to raise the matching exception.

Top module: `seg_guard`

## Requirements
- R1: After reset, and in the cycle after any edge where req_valid is low, res_valid is 0 and res_code is 0.
- R2: A request sampled at a rising edge gives res_valid=1, its verdict and lin_addr = (base + offset) mod 2^32 after that edge, with no other latency.
- R3: res_code values are 0 pass, 1 general-protection fault, 2 stack fault and 3 not-present fault. Operation codes are 0 read, 1 write, 2 data-register load, 3 stack load and 4 jump/call, and codes 5 to 7 give 1. Access-rights bit 7 is present, bits 6..5 are DPL and bit 4 is S (1 = code/data). For S=1, bit 3 is E (1 = code) and bit 0 is ignored. For data, bit 2 is expand-down and bit 1 is writable; for code, bit 2 is conforming and bit 1 is readable.
- R4: When bit 7 is 0, the verdict is 3 for every operation and overrides every other fault.
- R5: A data-register load (op 2) passes only for data or readable code with DPL >= max(CPL, RPL); otherwise the verdict is 1.
- R6: A stack load (op 3) passes only for writable data with DPL = CPL and RPL = CPL; every violation gives 2, never 1.
- R7: A jump/call (op 4) needs a code segment. A non-conforming target needs CPL = DPL and a conforming target needs CPL >= DPL. A violation gives 1.
- R8: A read of a system segment or of code with R=0 gives 1. A write to a system segment, to code, or to data with W=0 gives 1.
- R9: The effective limit is the 20-bit limit when gran=0, and limit*4096+4095 when gran=1.
- R10: For reads and writes of code or expand-up data, offset+size (size = bytes-1, 0..3) must not exceed the effective limit, else 1.
- R11: For expand-down data, the offset must be strictly above the effective limit and offset+size must not exceed FFFFFFFFh, else 1.
- R12: Access rights FEh decode as present, DPL 3, conforming readable code: a jump from CPL 3 and a read pass, and a write faults with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation kind (R3) |
| size | input | 2 | Access size in bytes minus one |
| acc_rights | input | 8 | Descriptor access-rights byte |
| base | input | 32 | Segment base |
| limit | input | 20 | Raw segment limit |
| gran | input | 1 | Limit unit: 0 byte, 1 4 KB page |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Selector requested privilege level |
| offset | input | 32 | Offset within the segment |
| res_valid | output | 1 | Verdict valid |
| res_code | output | 2 | Verdict (R3) |
| lin_addr | output | 32 | base + offset |

## Verification
Presence, type and privilege rules can all fail in the same cycle. The limit rules can also fail in that cycle, so the verdict depends on fault priority. The bench sweeps every access-rights byte against every CPL/RPL pair and every operation. Many of these requests have bit 7 clear together with a privilege or type violation, and each such request must report not-present. The limit sweep then pairs read-only or code segments with offsets just across the boundary. In those cases the type fault and the limit fault fall together, and the bench requires a single general-protection verdict. The bench judges each verdict against its own arithmetic model of the rules.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int AW = 32,
  parameter int LW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [7:0]    acc_rights,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] limit,
  input  logic          gran,
  input  logic [1:0]    cpl,
  input  logic [1:0]    rpl,
  input  logic [AW-1:0] offset,
  output logic          res_valid,
  output logic [1:0]    res_code,
  output logic [AW-1:0] lin_addr
);
  localparam int PGB = 12;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_LDD = 3'd2, OP_LDS = 3'd3, OP_XFR = 3'd4;
  localparam logic [1:0] V_OK = 2'd0, V_GP = 2'd1, V_SS = 2'd2, V_NP = 2'd3;

  wire       present = acc_rights[7];
  wire [1:0] dpl     = acc_rights[6:5];
  wire       is_seg  = acc_rights[4];
  wire       is_code = is_seg & acc_rights[3];
  wire       is_data = is_seg & ~acc_rights[3];
  wire       flag2   = acc_rights[2];
  wire       flag1   = acc_rights[1];

  wire [AW-1:0] eff_lim = gran ? {limit[AW-PGB-1:0], {PGB{1'b1}}}
                               : {{(AW-LW){1'b0}}, limit};
  wire [AW:0]   last    = {1'b0, offset} + {{(AW-1){1'b0}}, size};
  wire          up_ok   = last <= {1'b0, eff_lim};
  wire          dn_ok   = (offset > eff_lim) && !last[AW];
  wire          lim_ok  = (is_data && flag2) ? dn_ok : up_ok;
  wire [1:0]    maxp    = (cpl > rpl) ? cpl : rpl;

  logic [1:0] verdict;
  always_comb begin
    verdict = V_OK;
    if (!present) verdict = V_NP;
    else begin
      case (op)
        OP_RD:  if (!is_seg || (is_code && !flag1) || !lim_ok) verdict = V_GP;
        OP_WR:  if (!is_data || !flag1 || !lim_ok) verdict = V_GP;
        OP_LDD: if (!is_seg || (is_code && !flag1) || dpl < maxp) verdict = V_GP;
        OP_LDS: if (!is_data || !flag1 || dpl != cpl || rpl != cpl) verdict = V_SS;
        OP_XFR: if (!is_code || (flag2 ? (cpl < dpl) : (cpl != dpl))) verdict = V_GP;
        default: verdict = V_GP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= V_OK;
      lin_addr  <= '0;
    end else begin
      res_valid <= req_valid;
      res_code  <= req_valid ? verdict : V_OK;
      lin_addr  <= base + offset;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && res_code == V_OK));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R4
  np_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !present) |=> (res_code == V_NP));
  // R6
  ss_only_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op != OP_LDS) |=> (res_code != V_SS));
  // R6
  stack_no_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_LDS) |=> (res_code != V_GP));
  // R11
  down_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && present && is_data && flag2 && op == OP_RD && offset <= eff_lim)
      |=> (res_code == V_GP));
endmodule

// File: tb/seg_guard_test.sv
`timescale 1ns/1ps
module seg_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [7:0]  acc_rights = '0;
  logic [31:0] base = '0;
  logic [19:0] limit = '0;
  logic        gran = 1'b0;
  logic [1:0]  cpl = '0;
  logic [1:0]  rpl = '0;
  logic [31:0] offset = '0;
  wire         res_valid;
  wire  [1:0]  res_code;
  wire  [31:0] lin_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .size(size),
    .acc_rights(acc_rights), .base(base), .limit(limit), .gran(gran),
    .cpl(cpl), .rpl(rpl), .offset(offset),
    .res_valid(res_valid), .res_code(res_code), .lin_addr(lin_addr)
  );

  function automatic logic [1:0] model(input logic [7:0] ar, input logic [19:0] lim,
      input logic g, input logic [1:0] c, input logic [1:0] r, input logic [2:0] o,
      input logic [31:0] off, input logic [1:0] sz);
    int     d  = int'(ar[6:5]);
    int     mx = (c > r) ? int'(c) : int'(r);
    longint eff = g ? longint'(lim) * 4096 + 4095 : longint'(lim);
    longint lo = longint'(off);
    longint hi = longint'(off) + longint'(sz);
    bit     s = ar[4];
    bit     e = ar[3];
    bit     inlim = (s && !e && ar[2]) ? (lo > eff && hi <= 64'hFFFF_FFFF) : (hi <= eff);
    if (!ar[7]) return 2'd3;
    case (o)
      3'd0: return (!s || (e && !ar[1]) || !inlim) ? 2'd1 : 2'd0;
      3'd1: return (!s || e || !ar[1] || !inlim) ? 2'd1 : 2'd0;
      3'd2: return (!s || (e && !ar[1]) || d < mx) ? 2'd1 : 2'd0;
      3'd3: return (!s || e || !ar[1] || d != int'(c) || r != c) ? 2'd2 : 2'd0;
      3'd4: return (!s || !e || (ar[2] ? (int'(c) < d) : (c != ar[6:5]))) ? 2'd1 : 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (ar=%02h op=%0d cpl=%0d rpl=%0d off=%0h)",
               tag, act, exp, acc_rights, op, cpl, rpl, offset);
    end
  endtask

  task automatic issue;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    chk("R1 reset valid", 32'(res_valid), 0);
    chk("R1 reset code", 32'(res_code), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle valid", 32'(res_valid), 0);

    // R3 R4 R5 R6 R7: every access-rights byte, privilege pair and operation
    limit = 20'hFFFFF; gran = 1'b0; size = 2'd3;
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int o = 0; o < 6; o++) begin
            acc_rights = 8'(a); cpl = 2'(c); rpl = 2'(r); op = 3'(o);
            offset = 32'h100 + 32'(a * 7);
            base = 32'hFFFF_F000 + 32'(a * 64 + c);
            issue();
            chk("R3 R4 R5 R6 R7 R8 verdict", 32'(res_code),
                32'(model(8'(a), limit, gran, 2'(c), 2'(r), 3'(o), offset, size)));
            chk("R2 valid", 32'(res_valid), 1);
            chk("R2 lin_addr", lin_addr, base + offset);
          end

    // R9 R10 R11: limit edges for expand-up, expand-down, read-only data, code
    cpl = 2'd0; rpl = 2'd0; base = 32'h1000;
    for (int k = 0; k < 5; k++)
      for (int g = 0; g < 2; g++)
        for (int l = 0; l < 3; l++)
          for (int dlt = -4; dlt <= 4; dlt++)
            for (int s = 0; s < 4; s++)
              for (int o = 0; o < 2; o++) begin
                logic [7:0] arv;
                logic [31:0] effv;
                case (k)
                  0: arv = 8'h92;
                  1: arv = 8'h96;
                  2: arv = 8'h90;
                  3: arv = 8'h9A;
                  default: arv = 8'h94;
                endcase
                acc_rights = arv; gran = g[0];
                limit = (l == 0) ? 20'h0 : (l == 1) ? 20'h1F : 20'hFFFFF;
                effv = gran ? {limit, 12'hFFF} : {12'h0, limit};
                offset = effv + 32'(dlt);
                size = 2'(s); op = 3'(o);
                issue();
                chk("R9 R10 R11 limit verdict", 32'(res_code),
                    32'(model(arv, limit, gran, cpl, rpl, op, offset, size)));
              end

    // R12: FEh descriptor
    acc_rights = 8'hFE; limit = 20'hFFFFF; gran = 1'b1; offset = 32'h40; size = 2'd1;
    cpl = 2'd3; rpl = 2'd3; op = 3'd4; issue();
    chk("R12 jump cpl3", 32'(res_code), 0);
    cpl = 2'd0; issue();
    chk("R12 jump cpl0 conforming below", 32'(res_code), 1);
    op = 3'd0; issue();
    chk("R12 read", 32'(res_code), 0);
    op = 3'd1; issue();
    chk("R12 write", 32'(res_code), 1);

    // R1: idle after traffic
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 idle after valid", 32'(res_valid), 0);
    chk("R1 idle after code", 32'(res_code), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule